// File: doc/BRIEF.md
# Split 32/32 Interval Timer

A register-mapped timer whose 64 bits of count state are operated as two independent 32-bit timers, a lower half and an upper half. Each half has a counter, a period and a 2-bit enable mode. Each half also has a reset-release bit in a global control word and its own interrupt line. The counters advance only on cycles where the shared clock-enable tick is high. A half counts only when its release bit is set, the global timer-mode field selects unchained dual operation and its enable mode is one-shot or continuous.

Software writes full 32-bit words over a simple bus: `we_i` with `addr_i` and `wdata_i` commits on the rising clock edge. Reads are combinational on `addr_i`. When a running half's counter equals its period on a tick, the half emits a one-cycle interrupt pulse. In continuous mode the counter then restarts at zero, so a period of all ones gives a free-running 32-bit counter. In one-shot mode the counter stops at the period and hardware returns the half's enable mode to disabled.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: Register map by byte offset: 0x10 lower counter, 0x14 upper counter, 0x18 lower period, 0x1C upper period, 0x20 control (lower enable mode in bits 7:6, upper in bits 23:22), 0x24 global control (bit 0 lower release, bit 1 upper release, bits 3:2 timer mode). Unused bits and unmapped offsets read 0.
- R3: A half adds one to its counter on a rising edge where tick_i is 1, its release bit is 1, the timer mode is 1 and its enable mode is 1 (one-shot) or 2 (continuous). It holds without a tick and holds with enable mode 0 or 3.
- R4: In continuous mode, a tick with counter equal to period makes the counter 0 and drives that half's interrupt high for exactly the following cycle.
- R5: In one-shot mode, a tick with counter equal to period pulses that half's interrupt for one cycle, leaves the counter at the period and sets that half's enable mode to 0.
- R6: While a half's release bit is 0, its counter is held at 0, counter writes are ignored and its interrupt stays low.
- R7: A counter write loads the written value and takes priority over a tick in the same cycle.
- R8: The halves are independent: each uses its own interrupt line and counting in one half leaves the other's counter unchanged.
- R9: With the timer mode at any value other than 1, neither half counts.
- R10: With a period of 0xFFFFFFFF in continuous mode, the counter steps from 0xFFFFFFFE to 0xFFFFFFFF with no interrupt, then wraps to 0 with an interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one count per high cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of a word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_lo_o | output | 1 | Lower-half match pulse |
| irq_hi_o | output | 1 | Upper-half match pulse |

## Verification
The checker watches every cycle for four things. An interrupt pulse must follow a tick. A continuous match must wrap the counter to zero, and a one-shot match must clear the enable mode. A half held by its release bit must show a zero counter and no interrupt, and a counter must stay still when there is no tick or write. The bench scenarios cover the rest. They check the register map and the masking of unused bits, and exact count values after sequences of ticks. They check that a counter write wins over a tick in the same cycle, that enable mode 3 and wrong timer-mode values stop counting, and that the halves stay independent. They also check the all-ones period wrap.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_CTRL   = 8'h20;
  localparam logic [7:0] OFF_GCTL   = 8'h24;

  localparam int unsigned MODE_LSB_LO = 6;
  localparam int unsigned MODE_LSB_HI = 22;
  localparam int unsigned GCTL_W      = 4;
  localparam int unsigned TMODE_LSB   = 2;
  localparam logic [1:0]  TMODE_DUAL  = 2'd1;
  localparam int unsigned NUM_HALVES  = 2;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_CONT = 2'd2,
    EN_RSVD = 2'd3
  } en_mode_e;
endpackage

// File: rtl/split_timer_half.sv
module split_timer_half
  import split_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic         prd_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         mode_we_i,
  input  en_mode_e     mode_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] prd_o,
  output en_mode_e     mode_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, prd_q;
  en_mode_e     mode_q;
  logic         irq_q;
  logic         armed, step, hit;

  assign armed = (mode_q == EN_ONCE) || (mode_q == EN_CONT);
  // a counter write in the same cycle suppresses counting
  assign step  = !hold_i && run_i && tick_i && armed && !cnt_we_i;
  assign hit   = step && (cnt_q == prd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prd_q  <= '0;
      mode_q <= EN_OFF;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit;

      if (hold_i)            cnt_q <= '0;
      else if (cnt_we_i)     cnt_q <= wdata_i;
      else if (hit) begin
        if (mode_q == EN_CONT) cnt_q <= '0;
      end
      else if (step)         cnt_q <= cnt_q + W'(1);

      if (prd_we_i) prd_q <= wdata_i;

      if (mode_we_i)                      mode_q <= mode_wdata_i;
      else if (hit && mode_q == EN_ONCE)  mode_q <= EN_OFF;
    end
  end

  assign cnt_o  = cnt_q;
  assign prd_o  = prd_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/split_timer_bus.sv
module split_timer_bus
  import split_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                                   we_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [NUM_HALVES-1:0][DATA_W-1:0]      cnt_i,
  input  logic [NUM_HALVES-1:0][DATA_W-1:0]      prd_i,
  input  en_mode_e [NUM_HALVES-1:0]              mode_i,
  input  logic [GCTL_W-1:0]                      gctl_i,
  output logic [NUM_HALVES-1:0]                  cnt_we_o,
  output logic [NUM_HALVES-1:0]                  prd_we_o,
  output logic                                   ctrl_we_o,
  output logic                                   gctl_we_o,
  output logic [DATA_W-1:0]                      rdata_o
);
  logic sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi, sel_ctrl, sel_gctl;

  assign sel_cnt_lo = (addr_i == ADDR_W'(OFF_CNT_LO));
  assign sel_cnt_hi = (addr_i == ADDR_W'(OFF_CNT_HI));
  assign sel_prd_lo = (addr_i == ADDR_W'(OFF_PRD_LO));
  assign sel_prd_hi = (addr_i == ADDR_W'(OFF_PRD_HI));
  assign sel_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_gctl   = (addr_i == ADDR_W'(OFF_GCTL));

  assign cnt_we_o  = {we_i && sel_cnt_hi, we_i && sel_cnt_lo};
  assign prd_we_o  = {we_i && sel_prd_hi, we_i && sel_prd_lo};
  assign ctrl_we_o = we_i && sel_ctrl;
  assign gctl_we_o = we_i && sel_gctl;

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_cnt_lo: rdata_o = cnt_i[0];
      sel_cnt_hi: rdata_o = cnt_i[1];
      sel_prd_lo: rdata_o = prd_i[0];
      sel_prd_hi: rdata_o = prd_i[1];
      sel_ctrl: begin
        rdata_o[MODE_LSB_LO +: 2] = mode_i[0];
        rdata_o[MODE_LSB_HI +: 2] = mode_i[1];
      end
      sel_gctl:   rdata_o[GCTL_W-1:0] = gctl_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic [NUM_HALVES-1:0][DATA_W-1:0] cnt_w, prd_w;
  en_mode_e [NUM_HALVES-1:0]         mode_w;
  logic [NUM_HALVES-1:0]             irq_w, cnt_we, prd_we;
  logic                              ctrl_we, gctl_we, run_dual;
  logic [GCTL_W-1:0]                 gctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gctl_q <= '0;
    else if (gctl_we) gctl_q <= wdata_i[GCTL_W-1:0];
  end

  assign run_dual = (gctl_q[TMODE_LSB +: 2] == TMODE_DUAL);

  split_timer_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .we_i      (we_i),
    .addr_i    (addr_i),
    .cnt_i     (cnt_w),
    .prd_i     (prd_w),
    .mode_i    (mode_w),
    .gctl_i    (gctl_q),
    .cnt_we_o  (cnt_we),
    .prd_we_o  (prd_we),
    .ctrl_we_o (ctrl_we),
    .gctl_we_o (gctl_we),
    .rdata_o   (rdata_o)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int unsigned LSB = (h == 0) ? MODE_LSB_LO : MODE_LSB_HI;
    split_timer_half #(.W(DATA_W)) u_half (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .hold_i       (!gctl_q[h]),
      .run_i        (run_dual),
      .tick_i       (tick_i),
      .cnt_we_i     (cnt_we[h]),
      .prd_we_i     (prd_we[h]),
      .wdata_i      (wdata_i),
      .mode_we_i    (ctrl_we),
      .mode_wdata_i (en_mode_e'(wdata_i[LSB +: 2])),
      .cnt_o        (cnt_w[h]),
      .prd_o        (prd_w[h]),
      .mode_o       (mode_w[h]),
      .irq_o        (irq_w[h])
    );
  end

  assign irq_lo_o = irq_w[0];
  assign irq_hi_o = irq_w[1];
endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk
  import split_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [DATA_W-1:0] cnt_lo,
  input logic [DATA_W-1:0] cnt_hi,
  input logic [1:0]        mode_lo,
  input logic [1:0]        mode_hi,
  input logic [GCTL_W-1:0] gctl
);
  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl;
  assign wr_cnt_lo = we_i && (addr_i == ADDR_W'(OFF_CNT_LO));
  assign wr_cnt_hi = we_i && (addr_i == ADDR_W'(OFF_CNT_HI));
  assign wr_ctrl   = we_i && (addr_i == ADDR_W'(OFF_CTRL));

  p_irq_lo_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> $past(tick_i));
  p_irq_hi_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> $past(tick_i));

  p_wrap_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o && $past(mode_lo) == 2'd2 && !$past(wr_cnt_lo)) |-> cnt_lo == '0);
  p_wrap_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hi_o && $past(mode_hi) == 2'd2 && !$past(wr_cnt_hi)) |-> cnt_hi == '0);

  p_once_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o && $past(mode_lo) == 2'd1 && !$past(wr_ctrl)) |-> mode_lo == 2'd0);
  p_once_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hi_o && $past(mode_hi) == 2'd1 && !$past(wr_ctrl)) |-> mode_hi == 2'd0);

  p_hold_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gctl[0] |=> (cnt_lo == '0 && !irq_lo_o));
  p_hold_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gctl[1] |=> (cnt_hi == '0 && !irq_hi_o));

  p_still_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_lo && gctl[0]) |=> $stable(cnt_lo));
  p_still_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_hi && gctl[1]) |=> $stable(cnt_hi));
endmodule

bind split_timer split_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o),
  .cnt_lo   (cnt_w[0]),
  .cnt_hi   (cnt_w[1]),
  .mode_lo  (mode_w[0]),
  .mode_hi  (mode_w[1]),
  .gctl     (gctl_q)
);

// File: tb/sim_split_timer.sv
`timescale 1ns/100ps
module sim_split_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_lo_o, irq_hi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  split_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
  );

  typedef struct {
    int          sel;   // 0 read data, 1 lower irq, 2 upper irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  // monitor
  initial forever begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = (it.sel == 0) ? rdata_o : (it.sel == 1) ? {31'b0, irq_lo_o} : {31'b0, irq_hi_o};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); addr_i = a;
    #1; push(0, exp, tag); ->chk_ev;
  endtask

  task automatic tick1();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic chk_irq(input logic lo, input logic hi, input string tag);
    #1; push(1, {31'b0, lo}, {tag, " irq_lo"}); push(2, {31'b0, hi}, {tag, " irq_hi"}); ->chk_ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h10, 32'h0, "R1 cnt_lo");
    rd(8'h14, 32'h0, "R1 cnt_hi");
    rd(8'h18, 32'h0, "R1 prd_lo");
    rd(8'h1C, 32'h0, "R1 prd_hi");
    rd(8'h20, 32'h0, "R1 ctrl");
    rd(8'h24, 32'h0, "R1 gctl");
    chk_irq(1'b0, 1'b0, "R1");

    // R2 map and masking
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0000_000F, "R2 gctl mask");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h00C0_00C0, "R2 ctrl mask");
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h7);
    rd(8'h24, 32'h7, "R2 gctl");
    rd(8'h28, 32'h0, "R2 unmapped 0x28");
    rd(8'h00, 32'h0, "R2 unmapped 0x00");
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, 32'h1234_5678, "R2 prd_hi");

    // R3 R4 continuous lower half, period 3
    wr(8'h18, 32'd3);
    wr(8'h20, 32'h0000_0080);
    tick1(); tick1(); tick1();
    rd(8'h10, 32'd3, "R3 cnt_lo after 3 ticks");
    rd(8'h14, 32'd0, "R8 cnt_hi idle");
    tick1();
    chk_irq(1'b1, 1'b0, "R4 match");
    rd(8'h10, 32'd0, "R4 wrap");
    chk_irq(1'b0, 1'b0, "R4 pulse ends");
    repeat (5) @(negedge clk_i);
    rd(8'h10, 32'd0, "R3 no tick no count");

    // R5 one-shot upper half, period 2, lower continuous
    wr(8'h1C, 32'd2);
    wr(8'h20, 32'h0040_0080);
    tick1(); tick1();
    tick1();
    chk_irq(1'b0, 1'b1, "R5 one-shot match");
    rd(8'h20, 32'h0000_0080, "R5 mode cleared");
    rd(8'h14, 32'd2, "R5 holds at period");
    rd(8'h10, 32'd3, "R8 lower kept counting");
    tick1();
    chk_irq(1'b1, 1'b0, "R8 lower match only");
    rd(8'h14, 32'd2, "R5 stopped");
    rd(8'h10, 32'd0, "R8 lower wrapped");

    // R7 write wins over tick
    wr_tick(8'h10, 32'd5);
    rd(8'h10, 32'd5, "R7 write priority");
    wr(8'h10, 32'd0);

    // R6 release bit holds lower half
    wr(8'h10, 32'h55);
    rd(8'h10, 32'h55, "R7 direct write");
    wr(8'h24, 32'h6);
    rd(8'h10, 32'h0, "R6 held clears");
    wr(8'h10, 32'h33);
    rd(8'h10, 32'h0, "R6 write ignored");
    tick1();
    chk_irq(1'b0, 1'b0, "R6 no irq");
    rd(8'h10, 32'h0, "R6 no count");

    // R9 timer-mode field
    wr(8'h24, 32'h3);
    tick1();
    rd(8'h10, 32'h0, "R9 tmode 0");
    wr(8'h24, 32'hB);
    tick1();
    rd(8'h10, 32'h0, "R9 tmode 2");
    wr(8'h24, 32'h7);
    tick1();
    rd(8'h10, 32'h1, "R9 tmode 1 counts");

    // R3 enable mode 3 does not count
    wr(8'h20, 32'h0000_00C0);
    tick1();
    rd(8'h10, 32'h1, "R3 mode 3 holds");
    rd(8'h20, 32'h0000_00C0, "R3 mode 3 readback");

    // R10 all-ones period
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0000_0080);
    wr(8'h10, 32'hFFFF_FFFE);
    tick1();
    chk_irq(1'b0, 1'b0, "R10 before wrap");
    rd(8'h10, 32'hFFFF_FFFF, "R10 top value");
    tick1();
    chk_irq(1'b1, 1'b0, "R10 wrap irq");
    rd(8'h10, 32'h0, "R10 wrapped");

    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule